// File: doc/BRIEF.md
# Micro-Operation Integer ALU with Condition Flags

This block is the integer execution stage for register-to-register micro-operations. Each issued operation takes a first source value, a second operand, and the current value of the destination register. The second operand is either a 64-bit register value or a signed 8-bit immediate. The operation also carries an opcode, an operand size, a flag-write mask and, for the move operation, an optional condition test. The block returns the new destination value, already merged into the old one at the operand size, and keeps the architectural condition flags in an internal register.

The flag register holds five bits: carry, parity, zero, sign and overflow. Carry-in for add-with-carry and subtract-with-borrow comes from this register, and so does the condition test for the conditional move. Operations therefore see the flags left by the previous operation, including when operations are issued back to back.

Control is a two-state machine. `ST_IDLE` means no result is pending, and `ST_DONE` means the result and flag registers were loaded on the last edge. The transition `GO_DONE` is taken on any cycle with `issue` high, from either state. The transition `GO_IDLE` is taken on any cycle with `issue` low. Reset forces `ST_IDLE`.

Top module: `uop_alu`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `result` is zero, `flags` is zero and `res_valid` is low.
- R2: An operation presented with `issue` high is captured on that rising edge: `res_valid` is high during the next cycle only. On cycles with `issue` low, `result` and `flags` hold their values.
- R3: With `use_imm`=1 the second operand is `imm8` sign-extended to 64 bits. With `use_imm`=0 it is `src2`. The operation is the same in both forms.
- R4: Opcodes are 0 add, 2 add-with-carry (src1+op2+CF), 5 subtract (src1−op2) and 3 subtract-with-borrow (src1−op2−CF). CF is the flag value held before the operation.
- R5: `size_sel` codes 0/1/2/3 mean 1/2/4/8 bytes. At 1 and 2 bytes the destination bits above the size keep their old value. At 4 bytes bits 63:32 become zero. At 8 bytes all 64 bits are written.
- R6: Flag bit positions are CF=0, PF=1, ZF=2, SF=3 and OF=4. ZF and SF are taken from the result truncated to the size, with SF being its top bit. PF is 1 when the low 8 result bits hold an even number of ones.
- R7: For add-type operations CF is the carry out at the operand size. Subtract-type operations use src1 + ~op2 + carry-in, where the carry-in is 1 for subtract and !CF for subtract-with-borrow, and CF is the carry out of that sum. OF is set when both addends share a sign at the size and the result sign differs.
- R8: Opcodes 4 and, 1 or and 6 xor clear CF and OF when the mask selects them.
- R9: Only flag bits whose `flag_mask` bit is 1 change. All other flag bits keep their previous value.
- R10: Opcode 7 writes `dest_old` × op2, truncated and merged at the size. It sets ZF/SF/PF as in R6 and clears CF and OF when they are selected.
- R11: Opcode 8 (move) writes src1 merged with op2 at the size, treating src1 as the old destination. It never changes any flag.
- R12: A move with `cond_en`=1 writes only if the condition `cond` holds on the current flags. Otherwise `result` equals `dest_old` in full. The condition bits 3:1 select O, C, Z, C|Z, S, P, S≠O or Z|(S≠O), and bit 0 inverts the test.
- R13: Opcodes 9 to 15 return `dest_old` unchanged and leave all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Operation present this cycle |
| op | input | 4 | Opcode |
| use_imm | input | 1 | Select immediate as second operand |
| imm8 | input | 8 | Signed immediate |
| src1 | input | 64 | First source value |
| src2 | input | 64 | Second source register value |
| dest_old | input | 64 | Current destination value |
| size_sel | input | 2 | Operand size code |
| flag_mask | input | 5 | Flags this operation may write |
| cond_en | input | 1 | Move is conditional |
| cond | input | 4 | Condition code for the move |
| res_valid | output | 1 | Result registered last edge |
| result | output | 64 | Merged destination value |
| flags | output | 5 | Flag register {OF,SF,ZF,PF,CF} |

## Verification
The hardest situations to reach are those that depend on flag history. Examples are a borrow-in on subtract, and a conditional move whose test involves overflow against sign. Both need the flag register placed in a chosen state by an earlier operation, because it cannot be loaded directly. The vector table is therefore ordered so that each entry leaves flags the next entry consumes, with partial masks that keep some bits set from older entries. A directed sweep then sets two distinct flag patterns through adds and runs every condition code against each of them.

// File: rtl/uop_alu_pkg.sv
package uop_alu_pkg;

    localparam int DATA_W = 64;
    localparam int IMM_W  = 8;
    localparam int FLAG_W = 5;
    localparam int OP_W   = 4;

    localparam int F_CF = 0;
    localparam int F_PF = 1;
    localparam int F_ZF = 2;
    localparam int F_SF = 3;
    localparam int F_OF = 4;

    localparam logic [OP_W-1:0] OP_ADD = 4'd0;
    localparam logic [OP_W-1:0] OP_OR  = 4'd1;
    localparam logic [OP_W-1:0] OP_ADC = 4'd2;
    localparam logic [OP_W-1:0] OP_SBB = 4'd3;
    localparam logic [OP_W-1:0] OP_AND = 4'd4;
    localparam logic [OP_W-1:0] OP_SUB = 4'd5;
    localparam logic [OP_W-1:0] OP_XOR = 4'd6;
    localparam logic [OP_W-1:0] OP_MUL = 4'd7;
    localparam logic [OP_W-1:0] OP_MOV = 4'd8;

    typedef enum logic [1:0] {
        SZ_1B = 2'd0,
        SZ_2B = 2'd1,
        SZ_4B = 2'd2,
        SZ_8B = 2'd3
    } size_e;

    // How an operation treats the flag register
    typedef enum logic [1:0] {
        FC_NONE  = 2'd0,
        FC_ARITH = 2'd1,
        FC_CLEAR = 2'd2
    } fclass_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } state_e;

    // Place val into base at the given size
    function automatic logic [DATA_W-1:0] merge_sized(
        input logic [DATA_W-1:0] base,
        input logic [DATA_W-1:0] val,
        input logic [1:0]        sz
    );
        logic [DATA_W-1:0] m;
        unique case (sz)
            SZ_1B:   m = {base[DATA_W-1:8],  val[7:0]};
            SZ_2B:   m = {base[DATA_W-1:16], val[15:0]};
            SZ_4B:   m = {{(DATA_W-32){1'b0}}, val[31:0]};
            default: m = val;
        endcase
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] width_mask(input logic [1:0] sz);
        logic [DATA_W-1:0] m;
        unique case (sz)
            SZ_1B:   m = {{(DATA_W-8){1'b0}},  8'hFF};
            SZ_2B:   m = {{(DATA_W-16){1'b0}}, 16'hFFFF};
            SZ_4B:   m = {{(DATA_W-32){1'b0}}, 32'hFFFF_FFFF};
            default: m = {DATA_W{1'b1}};
        endcase
        return m;
    endfunction

    function automatic int sign_pos(input logic [1:0] sz);
        int p;
        unique case (sz)
            SZ_1B:   p = 7;
            SZ_2B:   p = 15;
            SZ_4B:   p = 31;
            default: p = DATA_W - 1;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/uop_alu_opsel.sv
module uop_alu_opsel
    import uop_alu_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int IW = IMM_W
) (
    input  logic          use_imm,
    input  logic [IW-1:0] imm,
    input  logic [W-1:0]  reg_val,
    output logic [W-1:0]  op2
);
    localparam int EXT_W = W - IW;

    logic [W-1:0] imm_ext;

    generate
        if (EXT_W > 0) begin : g_ext
            assign imm_ext = {{EXT_W{imm[IW-1]}}, imm};
        end else begin : g_noext
            assign imm_ext = imm[W-1:0];
        end
    endgenerate

    assign op2 = use_imm ? imm_ext : reg_val;

endmodule

// File: rtl/uop_alu_exec.sv
module uop_alu_exec
    import uop_alu_pkg::*;
(
    input  logic [OP_W-1:0]   op,
    input  logic [1:0]        size_sel,
    input  logic [DATA_W-1:0] src1,
    input  logic [DATA_W-1:0] op2,
    input  logic [DATA_W-1:0] dest_old,
    input  logic              cf_in,
    output logic [DATA_W-1:0] merged,
    output logic              add_cf,
    output logic              add_of,
    output fclass_e           fclass,
    output logic              is_mov,
    output logic              op_known
);
    logic              sub_mode;
    logic              cin;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   sum;
    logic [DATA_W-1:0] core;
    logic [DATA_W-1:0] product;
    int                sp;

    // Operation decode
    always_comb begin
        sub_mode = 1'b0;
        cin      = 1'b0;
        fclass   = FC_NONE;
        is_mov   = 1'b0;
        op_known = 1'b1;
        unique case (op)
            OP_ADD: fclass = FC_ARITH;
            OP_ADC: begin fclass = FC_ARITH; cin = cf_in; end
            OP_SUB: begin fclass = FC_ARITH; sub_mode = 1'b1; cin = 1'b1; end
            OP_SBB: begin fclass = FC_ARITH; sub_mode = 1'b1; cin = ~cf_in; end
            OP_AND, OP_OR, OP_XOR, OP_MUL: fclass = FC_CLEAR;
            OP_MOV: is_mov = 1'b1;
            default: op_known = 1'b0;
        endcase
    end

    assign b_eff   = sub_mode ? ~op2 : op2;
    assign sum     = {1'b0, src1} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};
    assign product = dest_old * op2;

    // Carry and overflow taken at the operand size
    always_comb begin
        sp = sign_pos(size_sel);
        unique case (size_sel)
            SZ_1B:   add_cf = sum[8]  ^ src1[8]  ^ b_eff[8];
            SZ_2B:   add_cf = sum[16] ^ src1[16] ^ b_eff[16];
            SZ_4B:   add_cf = sum[32] ^ src1[32] ^ b_eff[32];
            default: add_cf = sum[DATA_W];
        endcase
        add_of = (src1[sp] == b_eff[sp]) && (sum[sp] != src1[sp]);
    end

    always_comb begin
        unique case (op)
            OP_AND:  core = src1 & op2;
            OP_OR:   core = src1 | op2;
            OP_XOR:  core = src1 ^ op2;
            OP_MUL:  core = product;
            OP_MOV:  core = op2;
            default: core = sum[DATA_W-1:0];
        endcase
    end

    assign merged = merge_sized(is_mov ? src1 : dest_old, core, size_sel);

endmodule

// File: rtl/uop_alu_flagunit.sv
module uop_alu_flagunit
    import uop_alu_pkg::*;
(
    input  logic [DATA_W-1:0] res,
    input  logic [1:0]        size_sel,
    input  logic [FLAG_W-1:0] flags_q,
    input  logic [FLAG_W-1:0] mask,
    input  logic              add_cf,
    input  logic              add_of,
    input  fclass_e           fclass,
    output logic [FLAG_W-1:0] flags_d
);
    logic [FLAG_W-1:0] calc;
    logic [DATA_W-1:0] trunc;

    assign trunc = res & width_mask(size_sel);

    always_comb begin
        calc        = '0;
        calc[F_ZF]  = (trunc == '0);
        calc[F_SF]  = res[sign_pos(size_sel)];
        calc[F_PF]  = ~^res[7:0];
        calc[F_CF]  = (fclass == FC_ARITH) ? add_cf : 1'b0;
        calc[F_OF]  = (fclass == FC_ARITH) ? add_of : 1'b0;
    end

    genvar gi;
    generate
        for (gi = 0; gi < FLAG_W; gi++) begin : g_bit
            assign flags_d[gi] = (mask[gi] && fclass != FC_NONE) ? calc[gi] : flags_q[gi];
        end
    endgenerate

endmodule

// File: rtl/uop_alu_cond.sv
module uop_alu_cond
    import uop_alu_pkg::*;
(
    input  logic [3:0]        cc,
    input  logic [FLAG_W-1:0] fl,
    output logic              hit
);
    logic base;
    logic s_ne_o;

    assign s_ne_o = fl[F_SF] ^ fl[F_OF];

    always_comb begin
        unique case (cc[3:1])
            3'd0: base = fl[F_OF];
            3'd1: base = fl[F_CF];
            3'd2: base = fl[F_ZF];
            3'd3: base = fl[F_CF] | fl[F_ZF];
            3'd4: base = fl[F_SF];
            3'd5: base = fl[F_PF];
            3'd6: base = s_ne_o;
            default: base = fl[F_ZF] | s_ne_o;
        endcase
    end

    assign hit = base ^ cc[0];

endmodule

// File: rtl/uop_alu.sv
module uop_alu
    import uop_alu_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  issue,
    input  logic [3:0]            op,
    input  logic                  use_imm,
    input  logic [7:0]            imm8,
    input  logic [63:0]           src1,
    input  logic [63:0]           src2,
    input  logic [63:0]           dest_old,
    input  logic [1:0]            size_sel,
    input  logic [4:0]            flag_mask,
    input  logic                  cond_en,
    input  logic [3:0]            cond,
    output logic                  res_valid,
    output logic [63:0]           result,
    output logic [4:0]            flags
);
    state_e            state_q, state_d;
    logic [DATA_W-1:0] op2;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] res_d;
    logic [DATA_W-1:0] res_q;
    logic [FLAG_W-1:0] flags_q;
    logic [FLAG_W-1:0] flags_calc;
    logic              add_cf, add_of;
    fclass_e           fclass;
    logic              is_mov, op_known, cond_hit;

    uop_alu_opsel #(.W(DATA_W), .IW(IMM_W)) u_opsel (
        .use_imm (use_imm),
        .imm     (imm8),
        .reg_val (src2),
        .op2     (op2)
    );

    uop_alu_exec u_exec (
        .op       (op),
        .size_sel (size_sel),
        .src1     (src1),
        .op2      (op2),
        .dest_old (dest_old),
        .cf_in    (flags_q[F_CF]),
        .merged   (merged),
        .add_cf   (add_cf),
        .add_of   (add_of),
        .fclass   (fclass),
        .is_mov   (is_mov),
        .op_known (op_known)
    );

    uop_alu_flagunit u_flags (
        .res      (merged),
        .size_sel (size_sel),
        .flags_q  (flags_q),
        .mask     (flag_mask),
        .add_cf   (add_cf),
        .add_of   (add_of),
        .fclass   (fclass),
        .flags_d  (flags_calc)
    );

    uop_alu_cond u_cond (
        .cc  (cond),
        .fl  (flags_q),
        .hit (cond_hit)
    );

    // Destination selection: skipped moves and unknown opcodes keep dest_old
    always_comb begin
        if (!op_known || (is_mov && cond_en && !cond_hit))
            res_d = dest_old;
        else
            res_d = merged;
    end

    // Next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = issue ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = issue ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State and data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            res_q   <= '0;
            flags_q <= '0;
        end else begin
            state_q <= state_d;
            if (issue) begin
                res_q   <= res_d;
                flags_q <= flags_calc;
            end
        end
    end

    // Outputs
    always_comb begin
        res_valid = (state_q == ST_DONE);
        result    = res_q;
        flags     = flags_q;
    end

endmodule

// File: rtl/uop_alu_chk.sv
module uop_alu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        issue,
    input logic [3:0]  op,
    input logic [55:0] dest_hi,
    input logic [1:0]  size_sel,
    input logic [4:0]  flag_mask,
    input logic        res_valid,
    input logic [63:0] result,
    input logic [4:0]  flags
);
    AST_VALID_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> res_valid); // R2
    AST_NO_VALID_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> !res_valid); // R2
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> ($stable(result) && $stable(flags))); // R2
    AST_UNMASKED_FLAGS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> (((flags ^ $past(flags)) & ~$past(flag_mask)) == 5'd0)); // R9
    AST_LOGIC_CLEARS_CO: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && (op == 4'd1 || op == 4'd4 || op == 4'd6)) |=>
        (($past(flag_mask[0]) -> !flags[0]) && ($past(flag_mask[4]) -> !flags[4]))); // R8
    AST_MOVE_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op == 4'd8) |=> $stable(flags)); // R11
    AST_RESERVED_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op > 4'd8) |=> ($stable(flags) && result[63:8] == $past(dest_hi))); // R13
    AST_WORD4_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op <= 4'd7 && size_sel == 2'd2) |=> (result[63:32] == 32'd0)); // R5
    AST_BYTE_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op <= 4'd7 && size_sel == 2'd0) |=> (result[63:8] == $past(dest_hi))); // R5
endmodule

bind uop_alu uop_alu_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (issue),
    .op        (op),
    .dest_hi   (dest_old[63:8]),
    .size_sel  (size_sel),
    .flag_mask (flag_mask),
    .res_valid (res_valid),
    .result    (result),
    .flags     (flags)
);

// File: tb/uop_alu_tb.sv
`timescale 1ns/1ps
module uop_alu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [3:0]  op = '0;
    logic        use_imm = 1'b0;
    logic [7:0]  imm8 = '0;
    logic [63:0] src1 = '0, src2 = '0, dest_old = '0;
    logic [1:0]  size_sel = '0;
    logic [4:0]  flag_mask = '0;
    logic        cond_en = 1'b0;
    logic [3:0]  cond = '0;
    logic        res_valid;
    logic [63:0] result;
    logic [4:0]  flags;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    uop_alu u_dut (.*);

    typedef struct packed {
        logic [3:0]  vop;
        logic        vimm_en;
        logic [7:0]  vimm;
        logic [63:0] vs1;
        logic [63:0] vs2;
        logic [63:0] vd;
        logic [1:0]  vsz;
        logic [4:0]  vmask;
        logic        vcen;
        logic [3:0]  vcc;
        logic [3:0]  vreq;
        logic [63:0] eres;
        logic [4:0]  eflags;
    } vec_t;

    localparam int NV = 15;
    // flags {OF,SF,ZF,PF,CF}; each entry depends on flags left by the one before
    localparam vec_t VECS [NV] = '{
        // R7 add 1B, carry and overflow out of bit 7
        '{4'd0, 1'b0, 8'h00, 64'h1111_2222_3333_4480, 64'h80, 64'hAAAA_BBBB_CCCC_DDEE, 2'd0, 5'h1F, 1'b0, 4'h0, 4'd7,
          64'hAAAA_BBBB_CCCC_DD00, 5'h17},
        // R4 adc 2B with CF=1, immediate form
        '{4'd2, 1'b1, 8'h00, 64'h7FFF, 64'hFFFF, 64'h1234_5678_9ABC_DEF0, 2'd1, 5'h1F, 1'b0, 4'h0, 4'd4,
          64'h1234_5678_9ABC_8000, 5'h1A},
        // R7 sub 4B, CF is carry of src1+~op2+1
        '{4'd5, 1'b0, 8'h00, 64'h5, 64'h3, 64'hFFFF_FFFF_FFFF_FFFF, 2'd2, 5'h1F, 1'b0, 4'h0, 4'd7,
          64'h2, 5'h01},
        // R4 sbb 4B with CF=1: 3-5-1
        '{4'd3, 1'b0, 8'h00, 64'h3, 64'h5, 64'h0, 2'd2, 5'h1F, 1'b0, 4'h0, 4'd4,
          64'h0000_0000_FFFF_FFFD, 5'h08},
        // R6 and 8B gives zero
        '{4'd4, 1'b0, 8'h00, 64'hF0F0_F0F0_F0F0_F0F0, 64'h0F0F_0F0F_0F0F_0F0F, 64'h1, 2'd3, 5'h1F, 1'b0, 4'h0, 4'd6,
          64'h0, 5'h06},
        // R9 add 8B with CF-only mask, sign-extended imm
        '{4'd0, 1'b1, 8'h01, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, 2'd3, 5'h01, 1'b0, 4'h0, 4'd9,
          64'h0, 5'h07},
        // R8 xor 1B, mask CF|SF clears CF
        '{4'd6, 1'b1, 8'h0F, 64'hFF, 64'h0, 64'h5555_5555_5555_5555, 2'd0, 5'h09, 1'b0, 4'h0, 4'd8,
          64'h5555_5555_5555_55F0, 5'h0E},
        // R10 multiply 2B, 3 * -2
        '{4'd7, 1'b1, 8'hFE, 64'h0, 64'h0, 64'hAAAA_AAAA_AAAA_0003, 2'd1, 5'h1F, 1'b0, 4'h0, 4'd10,
          64'hAAAA_AAAA_AAAA_FFFA, 5'h0A},
        // R11 move 2B unconditional
        '{4'd8, 1'b0, 8'h00, 64'h1111_2222_3333_4444, 64'h9999_8888_7777_6666, 64'hDEAD, 2'd1, 5'h1F, 1'b0, 4'h0, 4'd11,
          64'h1111_2222_3333_6666, 5'h0A},
        // R12 move if sign, taken
        '{4'd8, 1'b0, 8'h00, 64'h7, 64'h0123_4567_89AB_CDEF, 64'h5, 2'd3, 5'h00, 1'b1, 4'h8, 4'd12,
          64'h0123_4567_89AB_CDEF, 5'h0A},
        // R12 move if zero, not taken: whole dest kept
        '{4'd8, 1'b0, 8'h00, 64'h7, 64'h1, 64'hCAFE_F00D_0BAD_BEEF, 2'd2, 5'h00, 1'b1, 4'h4, 4'd12,
          64'hCAFE_F00D_0BAD_BEEF, 5'h0A},
        // R12 move if less (S != O), taken, 4B
        '{4'd8, 1'b0, 8'h00, 64'h7, 64'hFFFF_FFFF_8765_4321, 64'h5, 2'd2, 5'h00, 1'b1, 4'hC, 4'd12,
          64'h0000_0000_8765_4321, 5'h0A},
        // R13 reserved opcode
        '{4'd15, 1'b0, 8'h00, 64'h1, 64'h2, 64'h0BAD_F00D_1234_5678, 2'd0, 5'h1F, 1'b0, 4'h0, 4'd13,
          64'h0BAD_F00D_1234_5678, 5'h0A},
        // R7 add 8B signed overflow
        '{4'd0, 1'b0, 8'h00, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 64'h0, 2'd3, 5'h1F, 1'b0, 4'h0, 4'd7,
          64'h8000_0000_0000_0000, 5'h1A},
        // R8 or 8B, OF-only mask clears OF
        '{4'd1, 1'b0, 8'h00, 64'h1, 64'h2, 64'h0, 2'd3, 5'h10, 1'b0, 4'h0, 4'd8,
          64'h3, 5'h0A}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [3:0] o, input logic ie, input logic [7:0] im,
                          input logic [63:0] a, input logic [63:0] b, input logic [63:0] d,
                          input logic [1:0] sz, input logic [4:0] m,
                          input logic ce, input logic [3:0] c);
        @(negedge clk);
        issue = 1'b1; op = o; use_imm = ie; imm8 = im; src1 = a; src2 = b;
        dest_old = d; size_sel = sz; flag_mask = m; cond_en = ce; cond = c;
        @(negedge clk);
        issue = 1'b0;
    endtask

    function automatic logic cond_ref(input logic [3:0] c, input logic [4:0] f);
        logic b;
        case (c[3:1])
            3'd0: b = f[4];
            3'd1: b = f[0];
            3'd2: b = f[2];
            3'd3: b = f[0] | f[2];
            3'd4: b = f[3];
            3'd5: b = f[1];
            3'd6: b = f[3] ^ f[4];
            default: b = f[2] | (f[3] ^ f[4]);
        endcase
        return b ^ c[0];
    endfunction

    task automatic sweep_cond(input logic [4:0] f);
        for (int c = 0; c < 16; c++) begin
            run_op(4'd8, 1'b0, 8'h0, 64'h0, 64'h1, 64'h2, 2'd3, 5'h1F, 1'b1, c[3:0]);
            chk($sformatf("R12 cond %0d", c), result, cond_ref(c[3:0], f) ? 64'h1 : 64'h2);
            chk($sformatf("R11 flags after cond %0d", c), {59'd0, flags}, {59'd0, f});
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 valid", {63'd0, res_valid}, 64'd0);
        chk("R1 result", result, 64'd0);
        chk("R1 flags", {59'd0, flags}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after release", {63'd0, res_valid}, 64'd0);
        chk("R1 flags after release", {59'd0, flags}, 64'd0);

        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i].vop, VECS[i].vimm_en, VECS[i].vimm, VECS[i].vs1, VECS[i].vs2,
                   VECS[i].vd, VECS[i].vsz, VECS[i].vmask, VECS[i].vcen, VECS[i].vcc);
            chk($sformatf("R%0d vec %0d result", VECS[i].vreq, i), result, VECS[i].eres);
            chk($sformatf("R%0d vec %0d flags", VECS[i].vreq, i), {59'd0, flags}, {59'd0, VECS[i].eflags});
            chk($sformatf("R2 vec %0d valid", i), {63'd0, res_valid}, 64'd1);
        end

        // R2 idle cycles hold result and flags, valid drops
        @(negedge clk);
        chk("R2 valid low when idle", {63'd0, res_valid}, 64'd0);
        chk("R2 result held", result, 64'h3);
        chk("R2 flags held", {59'd0, flags}, 64'h0A);

        // R3 register form equals immediate form (imm 0xF0 = -16)
        run_op(4'd0, 1'b1, 8'hF0, 64'h100, 64'h0, 64'h0, 2'd3, 5'h00, 1'b0, 4'h0);
        chk("R3 immediate sign-extended", result, 64'hF0);
        run_op(4'd0, 1'b0, 8'h00, 64'h100, 64'hFFFF_FFFF_FFFF_FFF0, 64'h0, 2'd3, 5'h00, 1'b0, 4'h0);
        chk("R3 register form", result, 64'hF0);

        // R12 condition sweep against flags 0x17 (OF,ZF,PF,CF set)
        run_op(4'd0, 1'b0, 8'h00, 64'h80, 64'h80, 64'h0, 2'd0, 5'h1F, 1'b0, 4'h0);
        chk("R7 setup flags A", {59'd0, flags}, 64'h17);
        sweep_cond(5'h17);
        // R12 sweep against flags 0x1A (OF,SF,PF set)
        run_op(4'd0, 1'b0, 8'h00, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 64'h0, 2'd3, 5'h1F, 1'b0, 4'h0);
        chk("R6 setup flags B", {59'd0, flags}, 64'h1A);
        sweep_cond(5'h1A);

        // R5 2-byte add keeps upper bits
        run_op(4'd0, 1'b0, 8'h00, 64'hFFFF, 64'h1, 64'h7777_6666_5555_4444, 2'd1, 5'h00, 1'b0, 4'h0);
        chk("R5 2B merge", result, 64'h7777_6666_5555_0000);

        // R1 reset in mid-run clears flags and result
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-run reset flags", {59'd0, flags}, 64'd0);
        chk("R1 mid-run reset result", result, 64'd0);
        rst_n = 1'b1;

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule